// File: doc/BRIEF.md
# Bidirectional Cascaded Column Code Sampler

This block sits at the front of a display column driver. On each shift clock it takes one 36-bit beat, which holds six 6-bit gray-level codes (two RGB pixels), and stores the beat in a per-column data store. A one-hot token moves through a chain of 64 stages and decides which group of six columns the beat goes into. One line of 384 column codes therefore takes 64 clocks.

A direction input sets which end the fill starts from. It also sets which start pin is the input and which one carries the pulse on to the next device. Identical devices can be chained this way: each one hands its carry pulse to the next on the same clock edge that writes its last group. An inversion input complements every code as it is stored.

The store has a registered read port addressed by group, so the downstream line latch can collect the stored line.

Top module: `column_code_sampler`

## Requirements
- R1: A beat on `pix_data` holds six codes. Code k occupies bits [6k+5:6k], with its LSB at bit 6k. A stored group word keeps the codes in the same bit positions, and this holds for both fill directions.
- R2: A group is written on the rising clock edge. The edge that accepts the start pulse writes the first group of the line. Each of the next 63 edges writes the next group in order, one group per edge.
- R3: With `fill_up` = 1, `sp_right_i` is the start input and the n-th group of the line is stored at group address n-1. With `fill_up` = 0, `sp_left_i` is the start input and the n-th group is stored at address 64-n.
- R4: The start pin on the output side is ignored as an input. The output pin on the input side is held low: `sp_right_o` is low when `fill_up` = 1, and `sp_left_o` is low when `fill_up` = 0.
- R5: The carry pin (`sp_left_o` when filling up, `sp_right_o` when filling down) goes high after the 64th rising edge counted from the edge that accepted the start, and stays high for exactly one clock.
- R6: No group is written outside the 64-edge fill window. Clocks with no token leave every stored word unchanged.
- R7: When `invert` = 1 during a write, each stored code is the bitwise complement of the input code. When `invert` = 0, the code is stored as it arrives.
- R8: A synchronous active-high `rst` clears the token chain and drives both carry pins low.
- R9: `rd_word` shows the word at group address `rd_grp` one clock after that address is applied. If the same group is written on that same edge, `rd_word` returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fill_up | input | 1 | 1: fill from group 0 upward; 0: fill from the top group downward |
| invert | input | 1 | Complement codes as they are stored |
| sp_right_i | input | 1 | Start pulse input when `fill_up` = 1 |
| sp_left_i | input | 1 | Start pulse input when `fill_up` = 0 |
| sp_right_o | output | 1 | Carry pulse when `fill_up` = 0, otherwise low |
| sp_left_o | output | 1 | Carry pulse when `fill_up` = 1, otherwise low |
| pix_data | input | 36 | Six 6-bit gray-level codes per beat |
| rd_grp | input | 6 | Group address for the read port |
| rd_word | output | 36 | Stored group word, one clock of read latency |

## Verification
The hardest case to reach from the pins is a read and a write that land on the same group on the same edge. A second hard case is when the inactive start pin toggles during a fill. The bench picks a random read address on every clock, so over many lines the read address often meets the moving write position. A behavioural model compares the result against the old-data rule on every clock. Throughout the lines the bench also pulses the unused start pin and drives random data during idle clocks. The model expects all of this to have no effect, and any write or carry it causes shows up as a miscompare.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  // Fill direction as seen on the fill_up input.
  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;

  localparam int unsigned DEF_STAGES = 64;
  localparam int unsigned DEF_CODES  = 6;
  localparam int unsigned DEF_CODE_W = 6;
endpackage

// File: rtl/token_chain.sv
// One-hot token chain: sel_o[i] is the write select for logical group i
// on the current edge. A start enters at stage 0.
module token_chain #(
  parameter int unsigned STAGES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [STAGES-1:0] sel_o
);
  logic [STAGES-2:0] tok_q;

  assign sel_o = {tok_q, start_i};

  always_ff @(posedge clk) begin
    if (rst) tok_q <= '0;
    else     tok_q <= sel_o[STAGES-2:0];
  end
endmodule

// File: rtl/slot_encoder.sv
// Turns the token selects into a write address and a write strobe.
module slot_encoder #(
  parameter int unsigned STAGES = 64,
  localparam int unsigned IDX_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] sel_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(STAGES); i++) begin
      if (sel_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |sel_i;
endmodule

// File: rtl/group_store.sv
// Single write port, registered read port (old data on a collision).
module group_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WORD_W = 36,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R9: with no write on the previous edge and the same address, read data holds
  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(we) && raddr == $past(raddr)) |=> $stable(rdata));
endmodule

// File: rtl/column_code_sampler.sv
module column_code_sampler
  import sampler_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES,
  parameter int unsigned CODES  = DEF_CODES,
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned WORD_W = CODES * CODE_W,
  localparam int unsigned IDX_W  = $clog2(STAGES),
  localparam int unsigned CNT_W  = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_up,
  input  logic              invert,
  input  logic              sp_right_i,
  input  logic              sp_left_i,
  output logic              sp_right_o,
  output logic              sp_left_o,
  input  logic [WORD_W-1:0] pix_data,
  input  logic [IDX_W-1:0]  rd_grp,
  output logic [WORD_W-1:0] rd_word
);
  fill_dir_e         dir;
  logic              start_eff;
  logic [STAGES-1:0] sel;
  logic [IDX_W-1:0]  log_idx;
  logic [IDX_W-1:0]  phys_idx;
  logic              sel_any;
  logic              we;
  logic [WORD_W-1:0] cond_word;

  assign dir       = fill_dir_e'(fill_up);
  assign start_eff = !rst && ((dir == FILL_UP) ? sp_right_i : sp_left_i);

  token_chain #(.STAGES(STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_eff),
    .sel_o  (sel)
  );

  slot_encoder #(.STAGES(STAGES)) u_enc (
    .sel_i(sel),
    .idx_o(log_idx),
    .any_o(sel_any)
  );

  // Mirror the group address when filling from the top end.
  assign phys_idx = (dir == FILL_UP) ? log_idx : IDX_W'(STAGES - 1) - log_idx;
  assign we       = sel_any && !rst;

  // Per-code conditioning: optional complement of each code.
  for (genvar c = 0; c < int'(CODES); c++) begin : g_code
    assign cond_word[c*CODE_W +: CODE_W] =
      invert ? ~pix_data[c*CODE_W +: CODE_W] : pix_data[c*CODE_W +: CODE_W];
  end

  group_store #(.DEPTH(STAGES), .WORD_W(WORD_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (we),
    .waddr(phys_idx),
    .wdata(cond_word),
    .raddr(rd_grp),
    .rdata(rd_word)
  );

  // Carry pins: registered, only the far-end pin ever pulses.
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_right_o <= 1'b0;
      sp_left_o  <= 1'b0;
    end else begin
      sp_right_o <= (dir == FILL_DOWN) && sel[STAGES-1];
      sp_left_o  <= (dir == FILL_UP)   && sel[STAGES-1];
    end
  end

  // Window counter used only by the checks below.
  logic [CNT_W-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                          since_q <= CNT_W'(STAGES);
    else if (start_eff)               since_q <= CNT_W'(1);
    else if (since_q < CNT_W'(STAGES)) since_q <= since_q + CNT_W'(1);
  end

  // R6: a write only happens on a start edge or inside the fill window
  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (start_eff || since_q < CNT_W'(STAGES)));

  // R5: the carry appears right after the edge that wrote the last group
  p_carry_timing_r5: assert property (@(posedge clk) disable iff (rst)
    (sp_right_o || sp_left_o) |-> ($past(since_q) == CNT_W'(STAGES - 1)));

  // R5: the carry pulse is one clock wide
  p_carry_single_r5: assert property (@(posedge clk) disable iff (rst)
    (sp_right_o || sp_left_o) |=> !(sp_right_o || sp_left_o));

  // R4: the pin on the input side stays low while direction is steady
  p_idle_pin_low_r4: assert property (@(posedge clk) disable iff (rst)
    (fill_up == $past(fill_up)) |-> (fill_up ? !sp_right_o : !sp_left_o));
endmodule

// File: tb/tb_column_code_sampler.sv
module tb_column_code_sampler;
  localparam int S      = 64;
  localparam int CODES  = 6;
  localparam int CW     = 6;
  localparam int WW     = CODES * CW;
  localparam int IW     = $clog2(S);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_up = 1'b1;
  logic          invert = 1'b0;
  logic          sp_right_i = 1'b0;
  logic          sp_left_i = 1'b0;
  logic          sp_right_o;
  logic          sp_left_o;
  logic [WW-1:0] pix_data = '0;
  logic [IW-1:0] rd_grp = '0;
  logic [WW-1:0] rd_word;

  column_code_sampler dut (
    .clk(clk), .rst(rst), .fill_up(fill_up), .invert(invert),
    .sp_right_i(sp_right_i), .sp_left_i(sp_left_i),
    .sp_right_o(sp_right_o), .sp_left_o(sp_left_o),
    .pix_data(pix_data), .rd_grp(rd_grp), .rd_word(rd_word)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscmp  = 0;
  bit    done    = 1'b0;
  string cur_req = "R8";

  // ---------------- behavioural reference model ----------------
  logic [WW-1:0] model_mem [S];
  bit            model_ok  [S];
  int            next_grp  = -1;   // logical group due on the next edge, -1 idle
  logic          exp_r = 1'b0, exp_l = 1'b0;
  logic [WW-1:0] exp_rd = '0;
  bit            exp_rd_ok = 1'b0;

  initial for (int i = 0; i < S; i++) model_ok[i] = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      next_grp = -1; exp_r = 1'b0; exp_l = 1'b0;
      exp_rd_ok = model_ok[rd_grp];
      exp_rd = model_mem[rd_grp];
    end else begin
      int  g;
      bit  sin;
      exp_rd_ok = model_ok[rd_grp];
      exp_rd    = model_mem[rd_grp];
      sin = fill_up ? sp_right_i : sp_left_i;
      g   = sin ? 0 : next_grp;
      if (g >= 0) begin
        int phys;
        phys = fill_up ? g : S - 1 - g;
        model_mem[phys] = invert ? ~pix_data : pix_data;
        model_ok[phys]  = 1'b1;
      end
      exp_l = fill_up  && (g == S - 1);
      exp_r = !fill_up && (g == S - 1);
      if (sin) next_grp = 1;
      else if (next_grp >= 0) next_grp = (next_grp == S - 1) ? -1 : next_grp + 1;
    end
  end

  // ---------------- comparison every clock ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (sp_right_o !== exp_r || sp_left_o !== exp_l) begin
        miscmp++;
        $display("FAIL R5/R4 (%s) carry pins r=%b l=%b expected r=%b l=%b at %0t",
                 cur_req, sp_right_o, sp_left_o, exp_r, exp_l, $time);
      end
      if (exp_rd_ok) begin
        vectors++;
        if (rd_word !== exp_rd) begin
          miscmp++;
          $display("FAIL %s R2 R9 rd_word=%h expected %h at %0t",
                   cur_req, rd_word, exp_rd, $time);
        end
      end
    end
  end

  // Random read address every clock, including collisions with the writer.
  always @(negedge clk) rd_grp <= IW'($urandom_range(0, S - 1));

  function automatic logic [WW-1:0] make_beat(int mode, int g, bit up);
    logic [WW-1:0] w;
    for (int c = 0; c < CODES; c++) begin
      int col;
      col = (up ? g : S - 1 - g) * CODES + c;
      case (mode)
        0: w[c*CW +: CW] = CW'($urandom);
        1: w[c*CW +: CW] = CW'(col);
        2: w[c*CW +: CW] = '1;
        default: w[c*CW +: CW] = CW'(c + 1);   // distinct code per slot
      endcase
    end
    return w;
  endfunction

  task automatic run_line(input bit up, input bit inv, input int mode,
                          input int idle, input bit junk);
    for (int k = 0; k < S; k++) begin
      @(negedge clk);
      fill_up  = up;
      invert   = inv;
      pix_data = make_beat(mode, k, up);
      if (up) begin
        sp_right_i = (k == 0);
        sp_left_i  = junk ? 1'($urandom) : 1'b0;
      end else begin
        sp_left_i  = (k == 0);
        sp_right_i = junk ? 1'($urandom) : 1'b0;
      end
    end
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      pix_data = WW'({$urandom, $urandom});
      invert   = 1'($urandom);
      if (up) begin sp_right_i = 1'b0; sp_left_i  = junk ? 1'($urandom) : 1'b0; end
      else    begin sp_left_i  = 1'b0; sp_right_i = junk ? 1'($urandom) : 1'b0; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: carry pins low after reset
    vectors++;
    if (sp_right_o !== 1'b0 || sp_left_o !== 1'b0) begin
      miscmp++;
      $display("FAIL R8 reset pins r=%b l=%b expected 0 0", sp_right_o, sp_left_o);
    end
    cur_req = "R1"; run_line(1'b1, 1'b0, 3, 4, 1'b0);
    cur_req = "R2"; run_line(1'b1, 1'b0, 1, 2, 1'b0);
    cur_req = "R3"; run_line(1'b0, 1'b0, 1, 4, 1'b0);
    cur_req = "R3"; run_line(1'b0, 1'b0, 0, 1, 1'b0);
    cur_req = "R7"; run_line(1'b1, 1'b1, 0, 3, 1'b0);
    cur_req = "R7"; run_line(1'b0, 1'b1, 2, 3, 1'b0);
    cur_req = "R4"; run_line(1'b1, 1'b0, 0, 5, 1'b1);
    cur_req = "R4"; run_line(1'b0, 1'b1, 0, 5, 1'b1);
    cur_req = "R6"; run_line(1'b1, 1'b0, 0, 150, 1'b1);
    cur_req = "R9";
    for (int n = 0; n < 6; n++) run_line(n[0], n[1], 0, 1 + n, 1'b1);
    cur_req = "R5"; run_line(1'b1, 1'b0, 1, 8, 1'b0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscmp++;
      $display("FAIL watchdog expired (%s) actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule